// File: doc/BRIEF.md
# Line-Alternating Phase-Correcting Clock Divider

This block takes a master clock running at six times the colour subcarrier and derives from it a half-rate system clock, three times the subcarrier. The subcarrier-to-line ratio is not a whole number, so on every second video line the divide-by-two stage is frozen for a single master-clock cycle. That freeze moves the derived clock by half a period, a 180-degree phase correction. The correction is timed from the horizontal sync-detect strobe.

The block also produces a one-cycle start pulse for the downstream line delays. The pulse is armed once per field by the vertical sync-detect strobe and fires on the next horizontal sync edge. A mode input chooses between comb operation and bypass. In bypass the divider, the line-parity toggle and the start logic stay idle. The mode actually in force is driven on a status output.

The divided clock leaves the block as a register output and a companion one-cycle enable, so downstream logic can stay on the master clock.

Top module: `phase_flip_clkdiv`

## Requirements
- R1: In comb operation `sys_clk` inverts on every master-clock edge except a stall edge, so it runs at half the master rate.
- R2: `sys_clk_en` is high in exactly those cycles in which `sys_clk` has just changed from 0 to 1.
- R3: A line-parity toggle, cleared by reset and in bypass, flips on each synchronised rising edge of `hsync_det`. An edge that leaves the toggle set (every second line, starting with the first) causes a stall.
- R4: If `hsync_det` is first sampled high at edge n and this causes a stall, `sys_clk` after edge n+3 equals its value after edge n+2. Exactly one edge is skipped.
- R5: `line_start` is high for exactly one cycle, after edge n+2, for the first `hsync_det` rising edge whose synchronised edge comes later than that of a `vsync_det` rising edge.
- R6: Each `vsync_det` edge allows at most one start pulse. An `hsync_det` edge that reaches the synchroniser output in the same cycle as a `vsync_det` edge does not fire the pulse for that field.
- R7: While `comb_sel` = 0 (bypass), `sys_clk`, `sys_clk_en` and `line_start` stay 0. Sync edges have no effect, and parity and arming restart cleared on return to comb.
- R8: `comb_active` equals the value `comb_sel` had at the previous master-clock edge (1 = comb, 0 = bypass).
- R9: A synchronous active-low `rst_n` clears the divider, the parity toggle, the arming flag, the synchronisers and all outputs at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mck | input | 1 | Master clock, six times subcarrier |
| rst_n | input | 1 | Synchronous reset, active low |
| comb_sel | input | 1 | Mode select: 1 comb, 0 bypass |
| hsync_det | input | 1 | Horizontal sync-detect strobe, asynchronous |
| vsync_det | input | 1 | Vertical sync-detect strobe, asynchronous |
| sys_clk | output | 1 | Half-rate system clock, register driven |
| sys_clk_en | output | 1 | One-cycle strobe at each rising step of `sys_clk` |
| line_start | output | 1 | One-cycle delay-line start pulse |
| comb_active | output | 1 | Mode in force: 1 comb, 0 bypass |

## Verification
The phase stall and the start pulse are both triggered by a horizontal sync edge, so they can fall on the same line. In that case the pulse lands one cycle before the frozen divider edge. The bench arms a field and then sends an odd-parity line, so both effects come from one edge. It then checks independently that the pulse appears after edge n+2 and that `sys_clk` holds across edge n+3. A second case drives the vertical and horizontal strobes on the same cycle. It checks that arming wins and that the pulse waits for the following line.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

    // Depth of the input synchroniser chain.
    localparam int unsigned PFD_SYNC_STAGES = 2;

    // Bit positions of the sync strobes inside the synchroniser bus.
    localparam int unsigned STB_H     = 0;
    localparam int unsigned STB_V     = 1;
    localparam int unsigned STB_COUNT = 2;

    // Divider and line-parity state.
    typedef struct packed {
        logic div;      // half-rate clock level
        logic en;       // rising-step strobe of div
        logic parity;   // line-parity toggle
        logic edge_seen;// horizontal edge seen last cycle
    } phase_state_t;

    // Field start state.
    typedef struct packed {
        logic armed;    // vertical edge seen, waiting for a line
        logic start;    // start pulse output
    } field_state_t;

endpackage

// File: rtl/pfd_sync_edge.sv
`timescale 1ns/1ps
module pfd_sync_edge #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] last_d;
    logic [WIDTH-1:0] last_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        last_d = chain_q[LAST];
        rise   = chain_q[LAST] & ~last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= '0;
            end
            last_q <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= chain_d[i];
            end
            last_q <= last_d;
        end
    end
endmodule

// File: rtl/pfd_line_phase.sv
`timescale 1ns/1ps
module pfd_line_phase
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic h_rise,
    output logic sys_clk,
    output logic sys_clk_en,
    output logic stall
);
    phase_state_t st_d;
    phase_state_t st_q;

    always_comb begin
        st_d  = st_q;
        // Freeze on the cycle after an edge that left the parity set.
        stall = st_q.edge_seen & st_q.parity;
        if (!run) begin
            st_d = '0;
        end else begin
            st_d.edge_seen = h_rise;
            if (h_rise) begin
                st_d.parity = ~st_q.parity;
            end
            if (!stall) begin
                st_d.div = ~st_q.div;
            end
            st_d.en = ~stall & ~st_q.div;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_clk    = st_q.div;
    assign sys_clk_en = st_q.en;
endmodule

// File: rtl/pfd_field_start.sv
`timescale 1ns/1ps
module pfd_field_start
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic h_rise,
    input  logic v_rise,
    output logic line_start
);
    field_state_t fs_d;
    field_state_t fs_q;

    always_comb begin
        fs_d       = fs_q;
        fs_d.start = run & h_rise & fs_q.armed;
        if (!run) begin
            fs_d.armed = 1'b0;
        end else if (v_rise) begin
            fs_d.armed = 1'b1;
        end else if (h_rise) begin
            fs_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign line_start = fs_q.start;
endmodule

// File: rtl/phase_flip_clkdiv.sv
`timescale 1ns/1ps
module phase_flip_clkdiv
    import pfd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = PFD_SYNC_STAGES
) (
    input  logic clk_mck,
    input  logic rst_n,
    input  logic comb_sel,
    input  logic hsync_det,
    input  logic vsync_det,
    output logic sys_clk,
    output logic sys_clk_en,
    output logic line_start,
    output logic comb_active
);
    logic [STB_COUNT-1:0] strobe_raw;
    logic [STB_COUNT-1:0] strobe_rise;
    logic                 h_rise_w;
    logic                 v_rise_w;
    logic                 stall_w;
    logic                 mode_d;
    logic                 mode_q;

    always_comb begin
        strobe_raw        = '0;
        strobe_raw[STB_H] = hsync_det;
        strobe_raw[STB_V] = vsync_det;
        h_rise_w          = strobe_rise[STB_H];
        v_rise_w          = strobe_rise[STB_V];
        mode_d            = comb_sel;
    end

    always_ff @(posedge clk_mck) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    pfd_sync_edge #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (STB_COUNT)
    ) u_sync (
        .clk      (clk_mck),
        .rst_n    (rst_n),
        .async_in (strobe_raw),
        .rise     (strobe_rise)
    );

    pfd_line_phase u_phase (
        .clk        (clk_mck),
        .rst_n      (rst_n),
        .run        (mode_q),
        .h_rise     (h_rise_w),
        .sys_clk    (sys_clk),
        .sys_clk_en (sys_clk_en),
        .stall      (stall_w)
    );

    pfd_field_start u_field (
        .clk        (clk_mck),
        .rst_n      (rst_n),
        .run        (mode_q),
        .h_rise     (h_rise_w),
        .v_rise     (v_rise_w),
        .line_start (line_start)
    );

    assign comb_active = mode_q;
endmodule

// File: rtl/pfd_checker.sv
`timescale 1ns/1ps
module pfd_checker (
    input logic clk,
    input logic rst_n,
    input logic comb_sel,
    input logic comb_active,
    input logic sys_clk,
    input logic sys_clk_en,
    input logic line_start,
    input logic stall,
    input logic h_rise
);
    logic past_ok;

    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    assert_mode_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (comb_active == $past(comb_sel)));

    assert_div_toggles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_active && !stall) |=> (sys_clk != $past(sys_clk)));

    assert_en_marks_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (sys_clk_en == (sys_clk && !$past(sys_clk))));

    assert_stall_after_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && stall) |-> $past(h_rise));

    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && comb_active) |=> $stable(sys_clk));

    assert_stall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);

    assert_bypass_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !comb_active |=> (!sys_clk && !sys_clk_en && !line_start));
endmodule

bind phase_flip_clkdiv pfd_checker u_chk (
    .clk         (clk_mck),
    .rst_n       (rst_n),
    .comb_sel    (comb_sel),
    .comb_active (comb_active),
    .sys_clk     (sys_clk),
    .sys_clk_en  (sys_clk_en),
    .line_start  (line_start),
    .stall       (stall_w),
    .h_rise      (h_rise_w)
);

// File: tb/phase_flip_clkdiv_bench.sv
`timescale 1ns/1ps
module phase_flip_clkdiv_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic comb_sel = 1'b0;
    logic hsync_det = 1'b0;
    logic vsync_det = 1'b0;
    logic sys_clk, sys_clk_en, line_start, comb_active;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int exp_start[$];
    int exp_stall[$];
    bit parity_exp = 1'b0;
    bit armed_exp  = 1'b0;
    bit prev_clk   = 1'b0;
    bit prev_comb  = 1'b0;
    bit finished   = 1'b0;

    phase_flip_clkdiv u_phase_flip_clkdiv (
        .clk_mck     (clk),
        .rst_n       (rst_n),
        .comb_sel    (comb_sel),
        .hsync_det   (hsync_det),
        .vsync_det   (vsync_det),
        .sys_clk     (sys_clk),
        .sys_clk_en  (sys_clk_en),
        .line_start  (line_start),
        .comb_active (comb_active)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Monitor: samples one time unit after each rising edge.
    initial forever begin
        @(posedge clk);
        #1;
        cyc++;
        if (!rst_n) begin
            // R9: reset clears every output
            check(!sys_clk && !sys_clk_en && !line_start && !comb_active, "R9",
                  {sys_clk, sys_clk_en, line_start, comb_active}, 0);
            prev_clk  = 1'b0;
            prev_comb = 1'b0;
        end else begin
            check(comb_active == comb_sel, "R8", comb_active, comb_sel);
            if (prev_comb) begin
                if (exp_stall.size() > 0 && exp_stall[0] == cyc) begin
                    void'(exp_stall.pop_front());
                    check(sys_clk == prev_clk, "R4 stall", sys_clk, prev_clk);
                end else begin
                    check(sys_clk != prev_clk, "R1 toggle", sys_clk, !prev_clk);
                end
            end else begin
                check(!sys_clk, "R7 idle clock", sys_clk, 0);
            end
            check(sys_clk_en == (sys_clk && !prev_clk), "R2 enable", sys_clk_en,
                  sys_clk && !prev_clk);
            if (exp_start.size() > 0 && exp_start[0] == cyc) begin
                void'(exp_start.pop_front());
                check(line_start, "R5 start", line_start, 1);
            end else begin
                check(!line_start, "R6 no start", line_start, 0);
            end
            prev_clk  = sys_clk;
            prev_comb = comb_active;
        end
    end

    // Driver: one sync strobe event, with expectations pushed to the scoreboard.
    task automatic strobe(input bit do_h, input bit do_v);
        int c;
        @(negedge clk);
        c = cyc;
        hsync_det = do_h;
        vsync_det = do_v;
        if (comb_sel) begin
            if (do_h) begin
                parity_exp = !parity_exp;
                if (armed_exp) exp_start.push_back(c + 3);   // R5
                if (parity_exp) exp_stall.push_back(c + 4);  // R3, R4
            end
            if (do_v) armed_exp = 1'b1;
            else if (do_h) armed_exp = 1'b0;
        end
        repeat (4) @(negedge clk);
        hsync_det = 1'b0;
        vsync_det = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic set_mode(input bit m);
        @(negedge clk);
        comb_sel = m;
        if (!m) begin
            parity_exp = 1'b0;
            armed_exp  = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        parity_exp = 1'b0;
        armed_exp  = 1'b0;
        exp_stall.delete();
        exp_start.delete();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: held in reset with comb requested
        comb_sel = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1, R3, R4: four plain lines, stalls on first and third
        for (int i = 0; i < 4; i++) strobe(1'b1, 1'b0);

        // R5: arm then fire; R6: second line of the field does not fire
        strobe(1'b0, 1'b1);
        strobe(1'b1, 1'b0);
        strobe(1'b1, 1'b0);

        // R6: vertical and horizontal on the same cycle, pulse waits a line
        strobe(1'b1, 1'b1);
        strobe(1'b1, 1'b0);

        // Start pulse and stall from the same horizontal edge
        if (parity_exp) strobe(1'b1, 1'b0);
        strobe(1'b0, 1'b1);
        strobe(1'b1, 1'b0);

        // R7: bypass ignores strobes, arming dropped
        strobe(1'b0, 1'b1);
        set_mode(1'b0);
        strobe(1'b0, 1'b1);
        strobe(1'b1, 1'b0);
        strobe(1'b1, 1'b0);
        set_mode(1'b1);
        // Parity restarts cleared, no stale arm
        strobe(1'b1, 1'b0);
        strobe(1'b1, 1'b0);

        // R9: reset mid-run clears parity and arming
        strobe(1'b0, 1'b1);
        pulse_reset();
        strobe(1'b1, 1'b0);
        strobe(1'b1, 1'b0);

        repeat (10) @(negedge clk);
        check(exp_start.size() == 0, "R5 pending", exp_start.size(), 0);
        check(exp_stall.size() == 0, "R4 pending", exp_stall.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule